// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This unit runs the bit-manipulation instruction group of an 8-bit microcontroller core. A one-bit carry register acts as the accumulator. The unit receives a decoded operation code, an 8-bit direct bit address, a signed 8-bit branch displacement, and the address of the byte that follows the current instruction. It reads the addressed bit from a local store of 256 single-bit cells. The lower half of the store stands for internal RAM bits and the upper half for special-register bits. It then updates either the carry or that bit.

The branch decision and the next program counter are combinational in the cycle the operation is presented. The bit or carry write takes effect on the clock edge that ends that cycle. The carry is also reachable as an ordinary bit at a fixed direct address, so any bit operation aimed at that address acts on the carry itself. Undefined operation codes are flagged and change nothing. There is no exclusive-OR code.

Top module: `bitproc_unit`

## Requirements
- R1: After reset the carry and every one of the 256 addressable bits read 0, and with no valid operation `branch_taken_o` and `illegal_o` are 0.
- R2: Addresses 00h–7Fh and 80h–FFh select separate cells: setting a bit at address A (A < 80h) leaves the bit at A+80h unchanged, and the reverse also holds.
- R3: Address D7h is the carry itself: reading it returns the carry, and set, clear, complement, move and test-and-clear aimed at it change the carry.
- R4: Codes 0 to 3 give C = C AND bit, C = C AND NOT bit, C = C OR bit and C = C OR NOT bit, in that order.
- R5: Code 4 copies the addressed bit into C; code 5 copies C into the addressed bit.
- R6: Codes 6, 8 and 10 clear, set and complement C; codes 7, 9 and 11 clear, set and complement the addressed bit.
- R7: Code 12 branches when C=1 and code 13 branches when C=0; neither changes any state.
- R8: Code 14 branches when the addressed bit is 1 and code 15 branches when it is 0; neither changes any state.
- R9: Code 16 branches when the addressed bit is 1 and clears that bit in the same operation; when the bit is 0 it does not branch and leaves the bit at 0.
- R10: A taken branch gives `pc_next_o` = `pc_next_in` + the sign-extended offset, modulo 2^16, so the reach is −128 to +127. Any operation that does not branch gives `pc_next_o` = `pc_next_in`.
- R11: Codes 17 to 31 are undefined (no exclusive-OR exists). With `op_valid` high they raise `illegal_o` in the same cycle, do not branch, and modify neither the carry nor any bit.
- R12: An operation completes in one clock: its branch outputs are valid in the cycle it is presented, and its write is visible from the next cycle. With `op_valid` low nothing changes and no branch or illegal flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Decoded operation code (0–16 defined) |
| bit_addr | input | 8 | Direct bit address |
| rel_ofs | input | 8 | Two's-complement branch displacement |
| pc_next_in | input | 16 | Address of the byte after the instruction |
| carry_o | output | 1 | Current carry (bit accumulator) |
| branch_taken_o | output | 1 | The presented operation branches |
| pc_next_o | output | 16 | Next program counter |
| illegal_o | output | 1 | The presented code is undefined |

## Verification
A corrupted store cell stays hidden until an operation reads it. It then shows up in the same cycle as a wrong branch decision on a bit test, or one cycle later as a wrong carry after a move or logic operation. A stray write is therefore found only when its address is read back. For that reason the bench sweeps every address after reset and after paired writes to aliased halves. A wrong carry is visible on `carry_o` at once and steers the next carry-conditioned branch, so the bench compares the carry, the branch flag, the next PC and the illegal flag against its model on every clock.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

   localparam int unsigned OPC_W = 5;

   typedef enum logic [OPC_W-1:0] {
      OP_AND_B   = 5'd0,
      OP_AND_NB  = 5'd1,
      OP_OR_B    = 5'd2,
      OP_OR_NB   = 5'd3,
      OP_LD_C    = 5'd4,
      OP_ST_C    = 5'd5,
      OP_CLR_C   = 5'd6,
      OP_CLR_B   = 5'd7,
      OP_SET_C   = 5'd8,
      OP_SET_B   = 5'd9,
      OP_INV_C   = 5'd10,
      OP_INV_B   = 5'd11,
      OP_BR_C1   = 5'd12,
      OP_BR_C0   = 5'd13,
      OP_BR_B1   = 5'd14,
      OP_BR_B0   = 5'd15,
      OP_BR_B1CL = 5'd16
   } bop_e;

   localparam logic [OPC_W-1:0] LAST_LEGAL = 5'd16;

   typedef struct packed {
      logic       wr_en;
      logic       wr_carry;
      logic       wr_val;
      logic       is_branch;
      logic       take;
      logic       legal;
   } bop_ctl_t;

endpackage

// File: rtl/bitproc_bank.sv
module bitproc_bank #(
   parameter int unsigned BITS  = 128,
   localparam int unsigned IDX_W = $clog2(BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_val
);

   logic [BITS-1:0] cells_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells_q <= '0;
      end else if (wr_en) begin
         cells_q[wr_idx] <= wr_val;
      end
   end

   assign rd_val = cells_q[rd_idx];

endmodule

// File: rtl/bitproc_store.sv
module bitproc_store #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned NUM_BANKS  = 2,
   parameter logic [7:0]  CARRY_ADDR = 8'hD7,
   localparam int unsigned BANK_SEL_W = $clog2(NUM_BANKS),
   localparam int unsigned BANK_BITS  = (2**ADDR_W) / NUM_BANKS,
   localparam int unsigned IDX_W      = ADDR_W - BANK_SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              wr_carry,
   input  logic              wr_val,
   output logic              rd_val,
   output logic              carry
);

   logic                  carry_q;
   logic                  hits_carry;
   logic                  carry_we;
   logic [NUM_BANKS-1:0]  bank_rd;
   logic [BANK_SEL_W-1:0] bank_sel;
   logic [IDX_W-1:0]      bank_idx;

   assign hits_carry = (addr == ADDR_W'(CARRY_ADDR));
   assign bank_sel   = addr[ADDR_W-1 -: BANK_SEL_W];
   assign bank_idx   = addr[IDX_W-1:0];
   assign carry_we   = wr_en && (wr_carry || hits_carry);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
      end else if (carry_we) begin
         carry_q <= wr_val;
      end
   end

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic bank_we;
      assign bank_we = wr_en && !wr_carry && !hits_carry &&
                       (bank_sel == BANK_SEL_W'(g));
      bitproc_bank #(
         .BITS (BANK_BITS)
      ) i_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (bank_we),
         .wr_idx (bank_idx),
         .wr_val (wr_val),
         .rd_idx (bank_idx),
         .rd_val (bank_rd[g])
      );
   end

   assign rd_val = hits_carry ? carry_q : bank_rd[bank_sel];
   assign carry  = carry_q;

endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
   import bitproc_pkg::*;
(
   input  logic             op_valid,
   input  logic [OPC_W-1:0] op_code,
   input  logic             bit_val,
   input  logic             carry,
   output bop_ctl_t         ctl
);

   bop_ctl_t raw;

   always_comb begin
      raw           = '0;
      raw.legal     = 1'b1;
      case (op_code)
         OP_AND_B:   begin raw.wr_en = 1'b1; raw.wr_carry = 1'b1; raw.wr_val = carry &  bit_val; end
         OP_AND_NB:  begin raw.wr_en = 1'b1; raw.wr_carry = 1'b1; raw.wr_val = carry & ~bit_val; end
         OP_OR_B:    begin raw.wr_en = 1'b1; raw.wr_carry = 1'b1; raw.wr_val = carry |  bit_val; end
         OP_OR_NB:   begin raw.wr_en = 1'b1; raw.wr_carry = 1'b1; raw.wr_val = carry | ~bit_val; end
         OP_LD_C:    begin raw.wr_en = 1'b1; raw.wr_carry = 1'b1; raw.wr_val = bit_val; end
         OP_ST_C:    begin raw.wr_en = 1'b1; raw.wr_val = carry; end
         OP_CLR_C:   begin raw.wr_en = 1'b1; raw.wr_carry = 1'b1; raw.wr_val = 1'b0; end
         OP_CLR_B:   begin raw.wr_en = 1'b1; raw.wr_val = 1'b0; end
         OP_SET_C:   begin raw.wr_en = 1'b1; raw.wr_carry = 1'b1; raw.wr_val = 1'b1; end
         OP_SET_B:   begin raw.wr_en = 1'b1; raw.wr_val = 1'b1; end
         OP_INV_C:   begin raw.wr_en = 1'b1; raw.wr_carry = 1'b1; raw.wr_val = ~carry; end
         OP_INV_B:   begin raw.wr_en = 1'b1; raw.wr_val = ~bit_val; end
         OP_BR_C1:   begin raw.is_branch = 1'b1; raw.take = carry; end
         OP_BR_C0:   begin raw.is_branch = 1'b1; raw.take = ~carry; end
         OP_BR_B1:   begin raw.is_branch = 1'b1; raw.take = bit_val; end
         OP_BR_B0:   begin raw.is_branch = 1'b1; raw.take = ~bit_val; end
         OP_BR_B1CL: begin
            raw.is_branch = 1'b1;
            raw.take      = bit_val;
            raw.wr_en     = bit_val;
            raw.wr_val    = 1'b0;
         end
         default:    raw.legal = 1'b0;
      endcase
   end

   always_comb begin
      ctl           = raw;
      ctl.legal     = raw.legal || !op_valid;
      ctl.wr_en     = raw.wr_en && raw.legal && op_valid;
      ctl.take      = raw.take && raw.is_branch && raw.legal && op_valid;
   end

endmodule

// File: rtl/bitproc_branch.sv
module bitproc_branch #(
   parameter int unsigned PC_W  = 16,
   parameter int unsigned REL_W = 8
) (
   input  logic [PC_W-1:0]  pc_in,
   input  logic [REL_W-1:0] rel,
   input  logic             take,
   output logic [PC_W-1:0]  pc_out
);

   logic [PC_W-1:0] rel_ext;

   if (PC_W > REL_W) begin : g_sext
      assign rel_ext = {{(PC_W-REL_W){rel[REL_W-1]}}, rel};
   end else begin : g_same
      assign rel_ext = rel[PC_W-1:0];
   end

   assign pc_out = take ? (pc_in + rel_ext) : pc_in;

endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
   import bitproc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned NUM_BANKS  = 2,
   parameter int unsigned PC_W       = 16,
   parameter int unsigned REL_W      = 8,
   parameter logic [7:0]  CARRY_ADDR = 8'hD7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [4:0]        op_code,
   input  logic [ADDR_W-1:0] bit_addr,
   input  logic [REL_W-1:0]  rel_ofs,
   input  logic [PC_W-1:0]   pc_next_in,
   output logic              carry_o,
   output logic              branch_taken_o,
   output logic [PC_W-1:0]   pc_next_o,
   output logic              illegal_o
);

   if (PC_W < REL_W) begin : g_bad_pc
      $error("bitproc_unit: PC_W must be at least REL_W");
   end
   if (NUM_BANKS < 2 || (2**ADDR_W) % NUM_BANKS != 0) begin : g_bad_bank
      $error("bitproc_unit: NUM_BANKS must be at least 2 and divide the bit space");
   end
   if (ADDR_W != 8) begin : g_bad_addr
      $error("bitproc_unit: carry alias assumes an 8-bit bit address");
   end

   bop_ctl_t ctl;
   logic     bit_val;
   logic     carry;

   bitproc_store #(
      .ADDR_W     (ADDR_W),
      .NUM_BANKS  (NUM_BANKS),
      .CARRY_ADDR (CARRY_ADDR)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bit_addr),
      .wr_en    (ctl.wr_en),
      .wr_carry (ctl.wr_carry),
      .wr_val   (ctl.wr_val),
      .rd_val   (bit_val),
      .carry    (carry)
   );

   bitproc_alu i_alu (
      .op_valid (op_valid),
      .op_code  (op_code),
      .bit_val  (bit_val),
      .carry    (carry),
      .ctl      (ctl)
   );

   bitproc_branch #(
      .PC_W  (PC_W),
      .REL_W (REL_W)
   ) i_branch (
      .pc_in  (pc_next_in),
      .rel    (rel_ofs),
      .take   (ctl.take),
      .pc_out (pc_next_o)
   );

   assign carry_o        = carry;
   assign branch_taken_o = ctl.take;
   assign illegal_o      = !ctl.legal;

endmodule

// File: rtl/bitproc_unit_chk.sv
module bitproc_unit_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned PC_W   = 16,
   parameter int unsigned REL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [4:0]        op_code,
   input logic [ADDR_W-1:0] bit_addr,
   input logic [REL_W-1:0]  rel_ofs,
   input logic [PC_W-1:0]   pc_next_in,
   input logic              carry_o,
   input logic              branch_taken_o,
   input logic [PC_W-1:0]   pc_next_o,
   input logic              illegal_o
);

   logic [PC_W-1:0] ofs_ext;
   assign ofs_ext = PC_W'($signed(rel_ofs));

   AST_ILLEGAL_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !branch_taken_o); // R11
   AST_ILLEGAL_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |=> $stable(carry_o)); // R11
   AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code > 5'd16) |-> illegal_o); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!branch_taken_o && !illegal_o)); // R12
   AST_IDLE_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(carry_o)); // R12
   AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (!rst_n)
      !branch_taken_o |-> (pc_next_o == pc_next_in)); // R10
   AST_TAKEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
      branch_taken_o |-> (pc_next_o == pc_next_in + ofs_ext)); // R10
   AST_BRANCH_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd12) |-> (branch_taken_o == carry_o)); // R7
   AST_BRANCH_ON_NCARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd13) |-> (branch_taken_o != carry_o)); // R7
   AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd6) |=> !carry_o); // R6
   AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd8) |=> carry_o); // R6
   AST_CARRY_FLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd10) |=> (carry_o != $past(carry_o))); // R6
   AST_ALIAS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd9 && bit_addr == 8'hD7) |=> carry_o); // R3

endmodule

bind bitproc_unit bitproc_unit_chk #(
   .ADDR_W (ADDR_W),
   .PC_W   (PC_W),
   .REL_W  (REL_W)
) i_bitproc_unit_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .op_valid       (op_valid),
   .op_code        (op_code),
   .bit_addr       (bit_addr),
   .rel_ofs        (rel_ofs),
   .pc_next_in     (pc_next_in),
   .carry_o        (carry_o),
   .branch_taken_o (branch_taken_o),
   .pc_next_o      (pc_next_o),
   .illegal_o      (illegal_o)
);

// File: tb/test_bitproc_unit.sv
module test_bitproc_unit;

   localparam int CARRY_A = 8'hD7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_code = '0;
   logic [7:0]  bit_addr = '0;
   logic [7:0]  rel_ofs = '0;
   logic [15:0] pc_next_in = '0;
   logic        carry_o;
   logic        branch_taken_o;
   logic [15:0] pc_next_o;
   logic        illegal_o;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;
   bit  mem [256];

   always #5 clk = ~clk;

   bitproc_unit i_bitproc_unit (
      .clk            (clk),
      .rst_n          (rst_n),
      .op_valid       (op_valid),
      .op_code        (op_code),
      .bit_addr       (bit_addr),
      .rel_ofs        (rel_ofs),
      .pc_next_in     (pc_next_in),
      .carry_o        (carry_o),
      .branch_taken_o (branch_taken_o),
      .pc_next_o      (pc_next_o),
      .illegal_o      (illegal_o)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   function automatic string tag_of(input int op);
      if (op <= 3)  return "R4";
      if (op <= 5)  return "R5";
      if (op <= 11) return "R6";
      if (op <= 13) return "R7";
      if (op <= 15) return "R8";
      if (op == 16) return "R9";
      return "R11";
   endfunction

   // Present one operation for one cycle and compare against the model.
   task automatic do_op(input bit v, input int op, input int a, input int r,
                        input int pc, input string tag_in);
      bit    b, c, take, ill, we;
      int    wa, wv, sr, exp_pc;
      string tag;
      tag = (tag_in == "") ? tag_of(op) : tag_in;
      @(negedge clk);
      op_valid   = v;
      op_code    = 5'(op);
      bit_addr   = 8'(a);
      rel_ofs    = 8'(r);
      pc_next_in = 16'(pc);
      #1;
      b = mem[a];
      c = mem[CARRY_A];
      take = 1'b0; we = 1'b0; wa = CARRY_A; wv = 0;
      ill  = v && (op > 16);
      if (v && !ill) begin
         case (op)
            0:  begin we = 1; wv = c & b;  end
            1:  begin we = 1; wv = c & !b; end
            2:  begin we = 1; wv = c | b;  end
            3:  begin we = 1; wv = c | !b; end
            4:  begin we = 1; wv = b; end
            5:  begin we = 1; wa = a; wv = c; end
            6:  begin we = 1; wv = 0; end
            7:  begin we = 1; wa = a; wv = 0; end
            8:  begin we = 1; wv = 1; end
            9:  begin we = 1; wa = a; wv = 1; end
            10: begin we = 1; wv = !c; end
            11: begin we = 1; wa = a; wv = !b; end
            12: take = c;
            13: take = !c;
            14: take = b;
            15: take = !b;
            16: begin take = b; if (b) begin we = 1; wa = a; wv = 0; end end
            default: ;
         endcase
      end
      sr     = (r >= 128) ? r - 256 : r;
      exp_pc = take ? ((pc + sr) & 16'hFFFF) : pc;
      check(branch_taken_o == take, tag, "branch_taken_o", branch_taken_o, take);
      check(pc_next_o == 16'(exp_pc), (tag == "R1") ? tag : "R10", "pc_next_o", pc_next_o, exp_pc);
      check(illegal_o == ill, (tag == "R1") ? tag : "R11", "illegal_o", illegal_o, ill);
      @(posedge clk);
      if (we) mem[wa] = wv[0];
      #1;
      check(carry_o == mem[CARRY_A], tag, "carry_o after edge (R12)", carry_o, mem[CARRY_A]);
   endtask

   initial begin : watchdog
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R12 watchdog expired: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : stim
      foreach (mem[i]) mem[i] = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(carry_o == 1'b0, "R1", "carry in reset", carry_o, 0);
      check(branch_taken_o == 1'b0, "R1", "branch in reset", branch_taken_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every bit reads 0 after reset (read via move-to-carry)
      for (int a = 0; a < 256; a++) do_op(1, 4, a, 0, 16'h0100, "R1");

      // R2: halves are distinct
      do_op(1, 9, 8'h05, 0, 0, "R2");
      do_op(1, 4, 8'h85, 0, 0, "R2");
      do_op(1, 14, 8'h85, 8'h10, 16'h0200, "R2");
      do_op(1, 14, 8'h05, 8'h10, 16'h0200, "R2");
      do_op(1, 9, 8'hF0, 0, 0, "R2");
      do_op(1, 4, 8'h70, 0, 0, "R2");

      // R3: carry alias at D7h
      do_op(1, 8, 0, 0, 0, "R3");
      do_op(1, 14, CARRY_A, 8'h04, 16'h0300, "R3");
      do_op(1, 7, CARRY_A, 0, 0, "R3");
      do_op(1, 11, CARRY_A, 0, 0, "R3");
      do_op(1, 16, CARRY_A, 8'h02, 16'h0310, "R3");
      do_op(1, 9, CARRY_A, 0, 0, "R3");
      do_op(1, 5, CARRY_A, 0, 0, "R3");

      // R4: logic with and without inversion over all input pairs
      for (int cv = 0; cv < 2; cv++)
         for (int bv = 0; bv < 2; bv++)
            for (int op = 0; op < 4; op++) begin
               do_op(1, bv ? 9 : 7, 8'h22, 0, 0, "R4");
               do_op(1, cv ? 8 : 6, 0, 0, 0, "R4");
               do_op(1, op, 8'h22, 0, 0, "R4");
            end

      // R5 / R6: moves and set/clear/complement
      do_op(1, 8, 0, 0, 0, "R5");
      do_op(1, 5, 8'h91, 0, 0, "R5");
      do_op(1, 6, 0, 0, 0, "R5");
      do_op(1, 4, 8'h91, 0, 0, "R5");
      do_op(1, 11, 8'h91, 0, 0, "R6");
      do_op(1, 4, 8'h91, 0, 0, "R6");
      do_op(1, 10, 0, 0, 0, "R6");
      do_op(1, 10, 0, 0, 0, "R6");

      // R7 / R8 / R9: branches
      do_op(1, 8, 0, 0, 0, "R7");
      do_op(1, 12, 0, 8'h05, 16'h1000, "R7");
      do_op(1, 13, 0, 8'h05, 16'h1000, "R7");
      do_op(1, 9, 8'h40, 0, 0, "R8");
      do_op(1, 14, 8'h40, 8'hFB, 16'h1000, "R8");
      do_op(1, 15, 8'h40, 8'hFB, 16'h1000, "R8");
      do_op(1, 16, 8'h40, 8'h20, 16'h2000, "R9");
      do_op(1, 16, 8'h40, 8'h20, 16'h2000, "R9");
      do_op(1, 4, 8'h40, 0, 0, "R9");

      // R10: offset extremes and wrap
      do_op(1, 8, 0, 0, 0, "R10");
      do_op(1, 12, 0, 8'h80, 16'h0050, "R10");
      do_op(1, 12, 0, 8'h7F, 16'hFFF0, "R10");
      do_op(1, 12, 0, 8'h00, 16'h1234, "R10");

      // R11: undefined codes change nothing
      do_op(1, 9, 8'h33, 0, 0, "R11");
      for (int op = 17; op < 32; op++) begin
         do_op(1, op, 8'h33, 8'h10, 16'h0400, "R11");
         do_op(1, op, CARRY_A, 8'h10, 16'h0400, "R11");
      end
      do_op(1, 4, 8'h33, 0, 0, "R11");

      // R12: idle cycles change nothing
      do_op(1, 6, 0, 0, 0, "R12");
      do_op(0, 8, 0, 8'h10, 16'h0500, "R12");
      do_op(0, 9, 8'h60, 0, 16'h0500, "R12");
      do_op(1, 4, 8'h60, 0, 0, "R12");

      // Mixed traffic over a narrow address set
      for (int i = 0; i < 4000; i++) begin
         int a, op;
         op = ($urandom_range(0, 19) < 18) ? $urandom_range(0, 16) : $urandom_range(17, 31);
         case ($urandom_range(0, 3))
            0: a = CARRY_A;
            1: a = $urandom_range(0, 7);
            2: a = 8'h80 + $urandom_range(0, 7);
            default: a = $urandom_range(0, 255);
         endcase
         do_op($urandom_range(0, 9) != 0, op, a, $urandom_range(0, 255),
               $urandom_range(0, 65535), "");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule